// File: doc/BRIEF.md
# Watchdog Mode Controller with Guarded Debug Unlock

This block supervises a host processor from inside a system-basis device. After power-on it sits in a normal-request state and fires a fixed-length reset pulse each time a watchdog period passes without the host configuring it. A write to the timing register moves it to Normal mode. In Normal mode the host must restart the watchdog with clear writes, or it receives a reset pulse and the controller drops back to normal-request.

For bench bring-up, the watchdog can be suspended in one of three debug modes (Normal, Standby and Stop debug). Entry is only possible through a strict order of writes made while the power-up battery-fail flag is still set. Entering debug consumes the flag, so debug can be entered only once per power-up. A host that wants to prevent debug entry reads the mode register: the read returns the flag and clears it. Commands arrive as decoded 8-bit bytes. Bits 7:5 are the address, bit 4 is the write flag and bits 3:0 are the data nibble. The mode register sits at address 000 and the timing register at address 010.

Top module: `wdt_mode_ctrl`

## Requirements
- R1: After a synchronous reset, `mode` is 000 (normal-request), `bat_flag` is 1, and both `rst_out` and `rd_flag` are 0.
- R2: In normal-request, `rst_out` rises PERIOD cycles after the reset is released or after the previous timeout, and it keeps repeating at that interval. A `wd_clr` in this state has no effect on the timing.
- R3: Each timeout drives `rst_out` high for exactly PULSE_LEN cycles. While `rst_out` is high, command bytes and `wd_clr` are ignored and `mode` does not change.
- R4: A timing-register write (byte 0101_xxxx) in normal-request sets `mode` to 001 (Normal) and restarts the watchdog period.
- R5: In Normal, a `wd_clr` restarts the period. A full period without a restart raises `rst_out`, and on that same edge `mode` returns to 000.
- R6: In Normal with `bat_flag` set, the mode write 0001_0000 arms debug. The next mode write selects the mode from the low data bits: x101 gives mode 101 (Normal debug), x110 gives 110 (Standby debug) and x111 gives 111 (Stop debug). Data bit 3 is ignored.
- R7: A debug-select write that was not preceded by an arming write leaves `mode` at 001. So does any other nonzero mode-register data written while armed, for example 1000; that write also disarms.
- R8: In any debug mode `rst_out` stays 0 however long no clear arrives. `bat_flag` is cleared when debug is entered.
- R9: A mode write of data 0000 while in a debug mode sets `mode` to 001 and starts a full watchdog period. The pulse therefore follows PERIOD cycles later if no clear arrives.
- R10: A mode-register read (byte 0000_xxxx) loads `rd_flag` with the current `bat_flag` and clears `bat_flag`. After that, the arming and select writes leave `mode` at 001 until the next reset.
- R11: In a debug mode a select write (x101, x110 or x111) switches to the named debug variant. Any other nonzero data leaves `mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| spi_stb | input | 1 | One-cycle strobe: a decoded command byte is valid |
| spi_byte | input | 8 | Command byte: address [7:5], write [4], data [3:0] |
| wd_clr | input | 1 | One-cycle watchdog-clear write |
| rst_out | output | 1 | Reset pulse to the host |
| mode | output | 3 | Current mode: 000 request, 001 Normal, 101/110/111 debug variants |
| bat_flag | output | 1 | Battery-fail flag from power-up |
| rd_flag | output | 1 | Flag value captured by the last mode-register read |

## Verification
A wrong period counter shows up as a `rst_out` edge one or more cycles away from the PERIOD-cycle mark. The bench catches it within one watchdog period of the last restart. A wrong arming or flag state is seen at the select write: `mode` takes or misses a debug code on the cycle right after that byte. `bat_flag` or `rd_flag` also differ in the cycle after a read or a debug entry. Because the reference model is compared on every clock, a divergence in any output is reported in the cycle it first appears.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

    localparam logic [2:0] MCR_ADDR = 3'b000;
    localparam logic [2:0] TIM_ADDR = 3'b010;

    typedef enum logic [2:0] {
        M_NREQ = 3'b000,
        M_NORM = 3'b001,
        M_NDBG = 3'b101,
        M_SDBG = 3'b110,
        M_PDBG = 3'b111
    } mode_e;

    typedef struct packed {
        logic       rd_mcr;
        logic       wr_mcr;
        logic       wr_tim;
        logic [3:0] data;
    } cmd_t;

    function automatic logic is_dbg(mode_e m);
        return m[2];
    endfunction

    function automatic logic sel_ok(logic [3:0] d);
        return d[2] && (d[1:0] != 2'b00);
    endfunction

    function automatic mode_e dbg_sel(logic [3:0] d);
        mode_e r;
        case (d[1:0])
            2'b01:   r = M_NDBG;
            2'b10:   r = M_SDBG;
            default: r = M_PDBG;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wmc_decode.sv
module wmc_decode
    import wmc_pkg::*;
(
    input  logic [7:0] byte_in,
    output cmd_t       cmd
);
    logic [2:0] addr;
    logic       wr;

    assign addr = byte_in[7:5];
    assign wr   = byte_in[4];

    always_comb begin
        cmd.rd_mcr = (addr == MCR_ADDR) && !wr;
        cmd.wr_mcr = (addr == MCR_ADDR) && wr;
        cmd.wr_tim = (addr == TIM_ADDR) && wr;
        cmd.data   = byte_in[3:0];
    end
endmodule

// File: rtl/wmc_wdog.sv
module wmc_wdog #(
    parameter int PERIOD    = 43_750_000,
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic hold,
    output logic timeout,
    output logic busy
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;

    assign timeout = !hold && !restart && (cnt == LAST);
    assign busy    = (pcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            if (hold || restart || timeout)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;

            if (timeout)
                pcnt <= PLEN;
            else if (busy)
                pcnt <= pcnt - 1'b1;
        end
    end
endmodule

// File: rtl/wmc_fsm.sv
module wmc_fsm
    import wmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  cmd_t  cmd,
    input  logic  wd_clr,
    input  logic  timeout,
    input  logic  busy,
    output mode_e mode,
    output logic  bf,
    output logic  rd_flag,
    output logic  restart,
    output logic  hold
);
    mode_e mode_q, mode_n;
    logic  bf_q, bf_n, arm_q, arm_n, rd_q, rd_n;
    logic  take, dbg;

    assign take = stb && !busy;
    assign dbg  = is_dbg(mode_q);
    assign hold = dbg;

    assign restart = (take && cmd.wr_tim && (mode_q == M_NREQ))
                   || (take && cmd.wr_mcr && (cmd.data == 4'b0000) && dbg)
                   || (wd_clr && !busy && (mode_q == M_NORM));

    always_comb begin
        mode_n = mode_q;
        bf_n   = bf_q;
        arm_n  = arm_q;
        rd_n   = rd_q;
        if (timeout) begin
            mode_n = M_NREQ;
            arm_n  = 1'b0;
        end else if (take) begin
            if (cmd.rd_mcr) begin
                rd_n = bf_q;
                bf_n = 1'b0;
            end else if (cmd.wr_tim) begin
                if (mode_q == M_NREQ)
                    mode_n = M_NORM;
            end else if (cmd.wr_mcr) begin
                if (cmd.data == 4'b0000) begin
                    if (dbg)
                        mode_n = M_NORM;
                    else if ((mode_q == M_NORM) && bf_q)
                        arm_n = 1'b1;
                end else if (sel_ok(cmd.data)) begin
                    if (dbg) begin
                        mode_n = dbg_sel(cmd.data);
                    end else if ((mode_q == M_NORM) && arm_q && bf_q) begin
                        mode_n = dbg_sel(cmd.data);
                        bf_n   = 1'b0;
                        arm_n  = 1'b0;
                    end else begin
                        arm_n = 1'b0;
                    end
                end else begin
                    arm_n = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_NREQ;
            bf_q   <= 1'b1;
            arm_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            mode_q <= mode_n;
            bf_q   <= bf_n;
            arm_q  <= arm_n;
            rd_q   <= rd_n;
        end
    end

    assign mode    = mode_q;
    assign bf      = bf_q;
    assign rd_flag = rd_q;
endmodule

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
    import wmc_pkg::*;
#(
    parameter int PERIOD    = 43_750_000,
    parameter int PULSE_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_stb,
    input  logic [7:0] spi_byte,
    input  logic       wd_clr,
    output logic       rst_out,
    output logic [2:0] mode,
    output logic       bat_flag,
    output logic       rd_flag
);
    cmd_t  cmd;
    mode_e mode_s;
    logic  restart, hold, timeout, busy;

    wmc_decode u_dec (
        .byte_in (spi_byte),
        .cmd     (cmd)
    );

    wmc_wdog #(
        .PERIOD    (PERIOD),
        .PULSE_LEN (PULSE_LEN)
    ) u_wd (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .hold    (hold),
        .timeout (timeout),
        .busy    (busy)
    );

    wmc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stb     (spi_stb),
        .cmd     (cmd),
        .wd_clr  (wd_clr),
        .timeout (timeout),
        .busy    (busy),
        .mode    (mode_s),
        .bf      (bat_flag),
        .rd_flag (rd_flag),
        .restart (restart),
        .hold    (hold)
    );

    assign rst_out = busy;
    assign mode    = mode_s;
endmodule

// File: rtl/wmc_chk.sv
module wmc_chk (
    input logic       clk,
    input logic       rst,
    input logic       spi_stb,
    input logic [7:0] spi_byte,
    input logic       rst_out,
    input logic [2:0] mode,
    input logic       bat_flag
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode == 3'b000 && bat_flag && !rst_out));

    a_r3_quiet_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_out |=> $stable(mode));

    a_r4_tim_enter: assert property (@(posedge clk) disable iff (rst)
        (spi_stb && !rst_out && spi_byte[7:4] == 4'b0101 && mode == 3'b000)
        |=> (mode == 3'b001));

    a_r5_pulse_to_req: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> (mode == 3'b000));

    a_r8_dbg_silent: assert property (@(posedge clk) disable iff (rst)
        mode[2] |-> (!rst_out && !bat_flag));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (spi_stb && !rst_out && spi_byte[7:4] == 4'b0000) |=> !bat_flag);
endmodule

bind wdt_mode_ctrl wmc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_stb  (spi_stb),
    .spi_byte (spi_byte),
    .rst_out  (rst_out),
    .mode     (mode),
    .bat_flag (bat_flag)
);

// File: tb/sim_wdt_mode_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_mode_ctrl;
    localparam int PER = 40;
    localparam int PL  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_stb = 1'b0;
    logic [7:0] spi_byte = 8'h00;
    logic       wd_clr = 1'b0;
    logic       rst_out, bat_flag, rd_flag;
    logic [2:0] mode;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    done   = 0;

    always #4 clk = ~clk;

    wdt_mode_ctrl #(.PERIOD(PER), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst(rst), .spi_stb(spi_stb), .spi_byte(spi_byte),
        .wd_clr(wd_clr), .rst_out(rst_out), .mode(mode),
        .bat_flag(bat_flag), .rd_flag(rd_flag)
    );

    // behavioural reference model
    int m_mode = 0, m_bf = 1, m_arm = 0, m_rd = 0, m_cnt = 0, m_pc = 0;

    always @(posedge clk) begin
        int a, w, d, nm, nbf, narm, nrd;
        bit busy, dbg, ok, rs, to;
        if (rst) begin
            m_mode = 0; m_bf = 1; m_arm = 0; m_rd = 0; m_cnt = 0; m_pc = 0;
        end else begin
            a = spi_byte[7:5]; w = spi_byte[4]; d = spi_byte[3:0];
            busy = (m_pc > 0);
            dbg  = (m_mode >= 5);
            ok   = spi_stb && !busy;
            rs = 0;
            if (ok && a == 2 && w == 1 && m_mode == 0) rs = 1;
            if (ok && a == 0 && w == 1 && d == 0 && dbg) rs = 1;
            if (wd_clr && !busy && m_mode == 1) rs = 1;
            to = !dbg && !rs && (m_cnt == PER - 1);
            nm = m_mode; nbf = m_bf; narm = m_arm; nrd = m_rd;
            if (to) begin
                nm = 0; narm = 0;
            end else if (ok && a == 0 && w == 0) begin
                nrd = m_bf; nbf = 0;
            end else if (ok && a == 2 && w == 1) begin
                if (m_mode == 0) nm = 1;
            end else if (ok && a == 0 && w == 1) begin
                if (d == 0) begin
                    if (dbg) nm = 1;
                    else if (m_mode == 1 && m_bf == 1) narm = 1;
                end else if ((d % 8) >= 5) begin
                    if (dbg) nm = d % 8;
                    else if (m_mode == 1 && m_arm == 1 && m_bf == 1) begin
                        nm = d % 8; nbf = 0; narm = 0;
                    end else narm = 0;
                end else narm = 0;
            end
            if (dbg || rs || to) m_cnt = 0; else m_cnt = m_cnt + 1;
            if (to) m_pc = PL; else if (busy) m_pc = m_pc - 1;
            m_mode = nm; m_bf = nbf; m_arm = narm; m_rd = nrd;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (mode !== 3'(m_mode) || rst_out !== (m_pc > 0) ||
                bat_flag !== 1'(m_bf) || rd_flag !== 1'(m_rd)) begin
                fails++;
                $display("FAIL %s model: mode=%0d/%0d rst_out=%0b/%0b bat_flag=%0b/%0b rd_flag=%0b/%0b (actual/expected)",
                         phase, mode, m_mode, rst_out, (m_pc > 0), bat_flag, m_bf, rd_flag, m_rd);
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic send(logic [7:0] b);
        spi_byte = b; spi_stb = 1'b1;
        @(negedge clk);
        spi_stb = 1'b0; spi_byte = 8'h00;
        @(negedge clk);
    endtask

    task automatic clr();
        wd_clr = 1'b1;
        @(negedge clk);
        wd_clr = 1'b0;
    endtask

    task automatic idle(int n, output bit saw);
        saw = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_out) saw = 1;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n, w;
        bit saw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        phase = "R1";
        chk("R1 mode", mode, 0);
        chk("R1 bat_flag", bat_flag, 1);
        chk("R1 rst_out", rst_out, 0);
        chk("R1 rd_flag", rd_flag, 0);

        // R2 periodic pulse in request state, clears ignored
        phase = "R2";
        while (!rst_out) @(negedge clk);
        clr();
        n = 1;
        while (rst_out) begin @(negedge clk); n++; end
        w = n;
        for (int i = 0; i < 5; i++) clr();
        n = n + 5;
        while (!rst_out) begin @(negedge clk); n++; end
        chk("R2 period", n, PER);
        chk("R3 width", w, PL);

        // R3 commands ignored during pulse
        phase = "R3";
        send(8'h50);
        chk("R3 mode held", mode, 0);
        while (rst_out) @(negedge clk);

        // R4 timing write enters Normal
        phase = "R4";
        send(8'h50);
        chk("R4 mode", mode, 1);

        // R5 clears keep alive, miss gives pulse
        phase = "R5";
        saw = 0;
        for (int k = 0; k < 4; k++) begin
            bit s;
            idle(30, s);
            if (s) saw = 1;
            clr();
        end
        chk("R5 no pulse", saw, 0);
        chk("R5 still normal", mode, 1);
        while (!rst_out) @(negedge clk);
        chk("R5 back to request", mode, 0);
        while (rst_out) @(negedge clk);

        // R7 wrong orders
        phase = "R7";
        send(8'h50);
        send(8'h15);
        chk("R7 select unarmed", mode, 1);
        send(8'h10);
        send(8'h18);
        send(8'h16);
        chk("R7 disarmed", mode, 1);
        clr();

        // R6 arm and enter with bit3 set
        phase = "R6";
        send(8'h10);
        send(8'h1D);
        chk("R6 normal debug", mode, 5);

        // R8 no timeout in debug
        phase = "R8";
        idle(150, saw);
        chk("R8 no pulse", saw, 0);
        chk("R8 flag cleared", bat_flag, 0);

        // R11 variant switching
        phase = "R11";
        send(8'h16);
        chk("R11 standby debug", mode, 6);
        send(8'h17);
        chk("R11 stop debug", mode, 7);
        send(8'h13);
        chk("R11 other ignored", mode, 7);

        // R9 exit restores supervision
        phase = "R9";
        send(8'h10);
        chk("R9 exit mode", mode, 1);
        n = 1;
        while (!rst_out) begin @(negedge clk); n++; end
        chk("R9 full period", n, PER);
        while (rst_out) @(negedge clk);

        // R10 flag consumed: no second entry; read path after new reset
        phase = "R10";
        send(8'h50);
        send(8'h10);
        send(8'h15);
        chk("R10 no reentry", mode, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        send(8'h50);
        send(8'h00);
        chk("R10 read flag", rd_flag, 1);
        chk("R10 flag cleared", bat_flag, 0);
        send(8'h10);
        send(8'h15);
        chk("R10 entry blocked", mode, 1);
        send(8'h00);
        chk("R10 second read", rd_flag, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule